// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block takes a single asynchronous serial line and turns it into parallel characters. Each bit cell is timed with a clock enable that runs at 1, 16 or 64 times the bit rate. A falling edge on an idle line starts a character. In the oversampled modes the start bit is confirmed at the middle of its cell, and every later bit is sampled one cell period after the bit before it. After the start bit come the data bits, least significant first, then an optional parity bit and a stop bit.

A completed character goes into a holding register and raises a ready flag, while the shift path is already free for the next character. That gives two levels of buffering. The host reads the character with a one-cycle read strobe. Four error flags report the faults on the line: parity mismatch, missing stop bit, line break and overrun. These flags stay set until the host pulses a clear strobe.

Top module: `async_rx_os`

## Requirements
- R1: After reset, `rdy_o`, `data_o` and all four error flags are zero.
- R2: `len_sel_i` sets the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits arrive least significant first and land in `data_o[0]` upward. Bits of `data_o` above the configured length read zero.
- R3: `mult_sel_i` sets the oversampling ratio: 0 is 1X, 1 is 16X, and 2 or 3 is 64X. In 16X and 64X the start bit is sampled half a cell after the enable tick that first sees the line low, and every later bit one full cell after the previous sample. In 1X every enable tick samples one bit.
- R4: In 16X or 64X, a start bit that is high at its mid-cell sample is dropped. The receiver returns to idle and produces no character.
- R5: When `par_en_i` is 1, a parity bit follows the data bits, and `par_err_o` is set if the parity check fails. With `par_odd_i`=1 the data bits plus the parity bit must hold an odd number of ones; with `par_odd_i`=0 that number must be even. When `par_en_i` is 0, no parity bit is expected and `par_err_o` is not set.
- R6: `frm_err_o` is set when the stop bit is sampled low.
- R7: `brk_o` is set when every data bit, the parity bit (if enabled) and the stop bit are all sampled low. After a low stop bit, the receiver waits for the line to go high before it looks for a new start bit, so a held break gives exactly one character.
- R8: `rdy_o` rises on the clock after the stop bit is sampled and falls on the clock after a `rd_i` pulse. `data_o` changes only when a character completes.
- R9: If a character completes while `rdy_o` is still set and `rd_i` is not pulsed in that cycle, the new character replaces the old one in `data_o` and `ovr_err_o` is set.
- R10: The error flags stay set until `err_clr_i` is pulsed. A read does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| samp_en_i | input | 1 | Oversample clock enable, one pulse per sampling tick |
| rx_i | input | 1 | Serial line, idle high |
| mult_sel_i | input | 2 | Oversampling ratio select (0: 1X, 1: 16X, 2/3: 64X) |
| len_sel_i | input | 2 | Character length select (0..3 gives 5..8 bits) |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | Odd parity when 1, even when 0 |
| rd_i | input | 1 | Read strobe for the holding register |
| err_clr_i | input | 1 | Clear strobe for the error flags |
| data_o | output | 8 | Received character |
| rdy_o | output | 1 | Character waiting in the holding register |
| par_err_o | output | 1 | Parity error flag |
| ovr_err_o | output | 1 | Overrun flag |
| frm_err_o | output | 1 | Framing error flag |
| brk_o | output | 1 | Line break flag |

## Verification
The receiver is fed clean characters at all three ratios and all four lengths, using bit patterns whose upper bits are set. A wrong ratio, a misplaced sample point or bits kept above the length all show up as wrong data. Parity is tried with good and corrupted bits under both senses, which separates a swapped sense from a dead check. A low stop bit with nonzero data is compared against an all-zero frame held low for several cells: the first must give a framing error alone, the second a break plus exactly one character. Short low glitches shorter than half a cell, followed by a valid character, show that a false start goes back to idle. Finally, two characters are received without a read in between, to show that the newer character overwrites the older one and that the overrun flag stays set until it is cleared.

// File: rtl/arx_pkg.sv
package arx_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4,
    S_MARK  = 3'd5
  } arx_state_e;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              par_err;
    logic              frm_err;
    logic              brk;
  } arx_char_t;

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], d_i};
  end

  // resets to the idle (mark) level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= sr_d;
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/arx_timer.sv
module arx_timer #(
  parameter int OS_MID = 16,
  parameter int OS_HI  = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       restart_i,
  input  logic [1:0] mult_i,
  output logic       strobe_o
);
  localparam int CW = $clog2(OS_HI);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] period_m1, first_m1;

  always_comb begin
    unique case (mult_i)
      2'd0: begin
        period_m1 = '0;
        first_m1  = '0;
      end
      2'd1: begin
        period_m1 = CW'(OS_MID - 1);
        first_m1  = CW'(OS_MID / 2 - 1);
      end
      default: begin
        period_m1 = CW'(OS_HI - 1);
        first_m1  = CW'(OS_HI / 2 - 1);
      end
    endcase
  end

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      if (restart_i)         cnt_d = first_m1;
      else if (cnt_q == '0)  cnt_d = period_m1;
      else                   cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign strobe_o = tick_i && !restart_i && (cnt_q == '0);
endmodule

// File: rtl/arx_framer.sv
module arx_framer
  import arx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic       strobe_i,
  input  logic [1:0] mult_i,
  input  logic [1:0] len_sel_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  output logic       restart_o,
  output logic       done_o,
  output arx_char_t  char_o
);
  arx_state_e        state_q, state_d;
  logic [2:0]        idx_q, idx_d;
  logic [CHAR_W-1:0] shf_q, shf_d;
  logic              pbit_q, pbit_d;
  logic              ones_q, ones_d;
  logic              done_q, done_d;
  arx_char_t         char_q, char_d;
  logic [2:0]        last_idx;

  assign last_idx = 3'd4 + {1'b0, len_sel_i};

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    shf_d     = shf_q;
    pbit_d    = pbit_q;
    ones_d    = ones_q;
    done_d    = 1'b0;
    char_d    = char_q;
    restart_o = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (tick_i && !rx_i) begin
          restart_o = 1'b1;
          shf_d     = '0;
          idx_d     = '0;
          pbit_d    = 1'b0;
          ones_d    = 1'b0;
          // at 1X the edge tick itself is the start sample
          state_d   = (mult_i == 2'd0) ? S_DATA : S_START;
        end
      end
      S_START: begin
        if (strobe_i) state_d = rx_i ? S_IDLE : S_DATA;
      end
      S_DATA: begin
        if (strobe_i) begin
          shf_d[idx_q] = rx_i;
          ones_d       = ones_q | rx_i;
          if (idx_q == last_idx) state_d = par_en_i ? S_PAR : S_STOP;
          else                   idx_d   = idx_q + 1'b1;
        end
      end
      S_PAR: begin
        if (strobe_i) begin
          pbit_d  = rx_i;
          ones_d  = ones_q | rx_i;
          state_d = S_STOP;
        end
      end
      S_STOP: begin
        if (strobe_i) begin
          done_d         = 1'b1;
          char_d.data    = shf_q;
          char_d.par_err = par_en_i & ((^shf_q) ^ pbit_q ^ par_odd_i);
          char_d.frm_err = !rx_i;
          char_d.brk     = !rx_i && !ones_q;
          state_d        = rx_i ? S_IDLE : S_MARK;
        end
      end
      S_MARK: begin
        if (tick_i && rx_i) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      shf_q   <= '0;
      pbit_q  <= 1'b0;
      ones_q  <= 1'b0;
      done_q  <= 1'b0;
      char_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      shf_q   <= shf_d;
      pbit_q  <= pbit_d;
      ones_q  <= ones_d;
      done_q  <= done_d;
      char_q  <= char_d;
    end
  end

  assign done_o = done_q;
  assign char_o = char_q;
endmodule

// File: rtl/arx_hold.sv
module arx_hold
  import arx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  arx_char_t         char_i,
  input  logic              rd_i,
  input  logic              clr_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              rdy_o,
  output logic              par_err_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              brk_o
);
  logic [CHAR_W-1:0] data_q, data_d;
  logic              rdy_q, rdy_d;
  logic [3:0]        flg_q, flg_d, flg_set;

  always_comb begin
    data_d = done_i ? char_i.data : data_q;
    if (done_i)    rdy_d = 1'b1;
    else if (rd_i) rdy_d = 1'b0;
    else           rdy_d = rdy_q;
    flg_set = '0;
    if (done_i) begin
      flg_set[0] = char_i.par_err;
      flg_set[1] = rdy_q && !rd_i;
      flg_set[2] = char_i.frm_err;
      flg_set[3] = char_i.brk;
    end
    flg_d = (flg_q & {4{!clr_i}}) | flg_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      flg_q  <= '0;
    end else begin
      data_q <= data_d;
      rdy_q  <= rdy_d;
      flg_q  <= flg_d;
    end
  end

  assign data_o    = data_q;
  assign rdy_o     = rdy_q;
  assign par_err_o = flg_q[0];
  assign ovr_err_o = flg_q[1];
  assign frm_err_o = flg_q[2];
  assign brk_o     = flg_q[3];
endmodule

// File: rtl/async_rx_os.sv
module async_rx_os
  import arx_pkg::*;
#(
  parameter int OS_MID      = 16,
  parameter int OS_HI       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_en_i,
  input  logic              rx_i,
  input  logic [1:0]        mult_sel_i,
  input  logic [1:0]        len_sel_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              rd_i,
  input  logic              err_clr_i,
  output logic [CHAR_W-1:0] data_o,
  output logic              rdy_o,
  output logic              par_err_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              brk_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;
  logic       rx_s;
  logic       restart;
  logic       strobe;
  logic       char_done;
  arx_char_t  char_w;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  arx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  arx_timer #(.OS_MID(OS_MID), .OS_HI(OS_HI)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .tick_i   (samp_en_i),
    .restart_i(restart),
    .mult_i   (mult_sel_i),
    .strobe_o (strobe)
  );

  arx_framer u_framer (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .tick_i   (samp_en_i),
    .rx_i     (rx_s),
    .strobe_i (strobe),
    .mult_i   (mult_sel_i),
    .len_sel_i(len_sel_i),
    .par_en_i (par_en_i),
    .par_odd_i(par_odd_i),
    .restart_o(restart),
    .done_o   (char_done),
    .char_o   (char_w)
  );

  arx_hold u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .done_i   (char_done),
    .char_i   (char_w),
    .rd_i     (rd_i),
    .clr_i    (err_clr_i),
    .data_o   (data_o),
    .rdy_o    (rdy_o),
    .par_err_o(par_err_o),
    .ovr_err_o(ovr_err_o),
    .frm_err_o(frm_err_o),
    .brk_o    (brk_o)
  );
endmodule

// File: rtl/arx_chk.sv
module arx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_i,
  input logic       err_clr_i,
  input logic       par_en_i,
  input logic       char_done,
  input logic [7:0] data_o,
  input logic       rdy_o,
  input logic       par_err_o,
  input logic       ovr_err_o,
  input logic       frm_err_o,
  input logic       brk_o
);
  p_rdy_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_done |=> rdy_o);

  p_rdy_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !char_done) |=> !rdy_o);

  p_data_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_done |=> $stable(data_o));

  p_ovr_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_done && rdy_o && !rd_i) |=> ovr_err_o);

  p_ovr_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_err_o) |-> $past(char_done && rdy_o));

  p_frm_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_err_o && !err_clr_i) |=> frm_err_o);

  p_ovr_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_err_o && !err_clr_i) |=> ovr_err_o);

  p_brk_frm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> frm_err_o);

  p_par_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(par_err_o) |-> $past(par_en_i));
endmodule

bind async_rx_os arx_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_i     (rd_i),
  .err_clr_i(err_clr_i),
  .par_en_i (par_en_i),
  .char_done(char_done),
  .data_o   (data_o),
  .rdy_o    (rdy_o),
  .par_err_o(par_err_o),
  .ovr_err_o(ovr_err_o),
  .frm_err_o(frm_err_o),
  .brk_o    (brk_o)
);

// File: tb/async_rx_os_tb_top.sv
`timescale 1ns/1ps
module async_rx_os_tb_top;

  typedef struct {
    logic [7:0] data;
    logic       par;
    logic       frm;
    logic       brk;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bcnt = 2'd0;
  logic       samp_en;
  logic       rx = 1'b1;
  logic [1:0] mult_sel = 2'd1;
  logic [1:0] len_sel = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       mon_rd = 1'b0, man_rd = 1'b0;
  logic       mon_clr = 1'b0, man_clr = 1'b0;
  logic       auto_rd = 1'b1;
  logic [7:0] data_o;
  logic       rdy_o, par_err_o, ovr_err_o, frm_err_o, brk_o;
  int         n_chk = 0;
  int         n_fail = 0;
  int         mulf = 16;
  exp_t       exp_q[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) bcnt <= bcnt + 2'd1;
  assign samp_en = (bcnt == 2'd3);

  async_rx_os dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .samp_en_i (samp_en),
    .rx_i      (rx),
    .mult_sel_i(mult_sel),
    .len_sel_i (len_sel),
    .par_en_i  (par_en),
    .par_odd_i (par_odd),
    .rd_i      (mon_rd | man_rd),
    .err_clr_i (mon_clr | man_clr),
    .data_o    (data_o),
    .rdy_o     (rdy_o),
    .par_err_o (par_err_o),
    .ovr_err_o (ovr_err_o),
    .frm_err_o (frm_err_o),
    .brk_o     (brk_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cells(input int n);
    repeat (n * mulf * 4) @(negedge clk);
  endtask

  task automatic set_cfg(input int mf, input int nbits, input bit pen, input bit podd);
    mulf     = mf;
    mult_sel = (mf == 1) ? 2'd0 : (mf == 16) ? 2'd1 : 2'd2;
    len_sel  = 2'(nbits - 5);
    par_en   = pen;
    par_odd  = podd;
  endtask

  // drives one frame; pushes the expected item when push is set
  task automatic send(input logic [7:0] d, input bit bad_par, input bit stop_v,
                      input int extra_low, input bit push, input string tag);
    int   nb;
    logic [7:0] dm;
    logic pb;
    exp_t e;
    nb = int'(len_sel) + 5;
    dm = d & 8'((1 << nb) - 1);
    pb = (par_odd ? ~^dm : ^dm) ^ bad_par;
    if (push) begin
      e.data = dm;
      e.par  = par_en & bad_par;
      e.frm  = !stop_v;
      e.brk  = !stop_v && (dm == 8'h00) && (!par_en || !pb);
      e.tag  = tag;
      exp_q.push_back(e);
    end
    @(negedge clk);
    while (bcnt != 2'd0) @(negedge clk);
    rx = 1'b0; cells(1);
    for (int i = 0; i < nb; i++) begin
      rx = dm[i]; cells(1);
    end
    if (par_en) begin
      rx = pb; cells(1);
    end
    rx = stop_v; cells(1);
    if (extra_low > 0) begin
      rx = 1'b0; cells(extra_low);
    end
    rx = 1'b1; cells(2);
  endtask

  // scoreboard monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (auto_rd && rdy_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected character", data_o, 0);
        end else begin
          e = exp_q.pop_front();
          chk(data_o == e.data, "R2", {e.tag, " data"}, data_o, e.data);
          chk(par_err_o == e.par, "R5", {e.tag, " parity flag"}, par_err_o, e.par);
          chk(frm_err_o == e.frm, "R6", {e.tag, " framing flag"}, frm_err_o, e.frm);
          chk(brk_o == e.brk, "R7", {e.tag, " break flag"}, brk_o, e.brk);
          chk(ovr_err_o == 1'b0, "R9", {e.tag, " no overrun"}, ovr_err_o, 0);
        end
        mon_rd = 1'b1; mon_clr = 1'b1;
        @(negedge clk);
        mon_rd = 1'b0; mon_clr = 1'b0;
        chk(rdy_o == 1'b0, "R8", "ready cleared by read", rdy_o, 0);
        chk({par_err_o, frm_err_o, brk_o} == 3'b000, "R10", "flags cleared by strobe",
            {par_err_o, frm_err_o, brk_o}, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({rdy_o, par_err_o, ovr_err_o, frm_err_o, brk_o} == 5'b0, "R1", "flags after reset",
        {rdy_o, par_err_o, ovr_err_o, frm_err_o, brk_o}, 0);
    chk(data_o == 8'h00, "R1", "data after reset", data_o, 0);

    // R3 16X, R2 lengths
    set_cfg(16, 8, 0, 0);
    send(8'hA5, 0, 1, 0, 1, "R3 16x 8b");
    send(8'h3C, 0, 1, 0, 1, "R2 8b");
    set_cfg(16, 5, 0, 0);
    send(8'hF5, 0, 1, 0, 1, "R2 5b");
    set_cfg(16, 6, 0, 0);
    send(8'hEA, 0, 1, 0, 1, "R2 6b");
    set_cfg(16, 7, 0, 0);
    send(8'hD9, 0, 1, 0, 1, "R2 7b");

    // R5 parity, both senses, good and bad
    set_cfg(16, 8, 1, 0);
    send(8'h37, 0, 1, 0, 1, "R5 even ok");
    send(8'h37, 1, 1, 0, 1, "R5 even bad");
    set_cfg(16, 7, 1, 1);
    send(8'h52, 0, 1, 0, 1, "R5 odd ok");
    send(8'h52, 1, 1, 0, 1, "R5 odd bad");

    // R3 other ratios
    set_cfg(1, 8, 0, 0);
    send(8'h96, 0, 1, 0, 1, "R3 1x");
    send(8'h01, 0, 1, 0, 1, "R3 1x b");
    set_cfg(64, 7, 1, 1);
    send(8'h4D, 0, 1, 0, 1, "R3 64x");

    // R6 framing without break
    set_cfg(16, 8, 0, 0);
    send(8'h81, 0, 0, 0, 1, "R6 stop low");

    // R7 break held low, then recovery
    send(8'h00, 0, 0, 4, 1, "R7 break");
    send(8'h5A, 0, 1, 0, 1, "R7 after break");

    // R4 false start at 16X and 64X
    rx = 1'b0; repeat (4 * 4) @(negedge clk);
    rx = 1'b1; cells(2);
    chk(rdy_o == 1'b0 && exp_q.size() == 0, "R4", "16x glitch ignored", rdy_o, 0);
    send(8'hC3, 0, 1, 0, 1, "R4 16x after glitch");
    set_cfg(64, 8, 0, 0);
    rx = 1'b0; repeat (20 * 4) @(negedge clk);
    rx = 1'b1; cells(2);
    chk(rdy_o == 1'b0 && exp_q.size() == 0, "R4", "64x glitch ignored", rdy_o, 0);
    send(8'h69, 0, 1, 0, 1, "R4 64x after glitch");

    // R9 overrun, R10 sticky
    set_cfg(16, 8, 0, 0);
    auto_rd = 1'b0;
    send(8'h11, 0, 1, 0, 0, "R9 first");
    chk(ovr_err_o == 1'b0 && rdy_o == 1'b1, "R9", "single unread char no overrun",
        {rdy_o, ovr_err_o}, 2);
    send(8'h22, 0, 1, 0, 0, "R9 second");
    chk(data_o == 8'h22, "R9", "newest char kept", data_o, 8'h22);
    chk(ovr_err_o == 1'b1, "R9", "overrun flag", ovr_err_o, 1);
    man_rd = 1'b1; @(negedge clk); man_rd = 1'b0;
    chk(rdy_o == 1'b0, "R8", "manual read clears ready", rdy_o, 0);
    repeat (5) @(negedge clk);
    chk(ovr_err_o == 1'b1, "R10", "overrun held after read", ovr_err_o, 1);
    man_clr = 1'b1; @(negedge clk); man_clr = 1'b0;
    chk(ovr_err_o == 1'b0, "R10", "overrun cleared by strobe", ovr_err_o, 0);
    auto_rd = 1'b1;

    cells(2);
    chk(exp_q.size() == 0, "R8", "all expected characters seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule